// File: doc/BRIEF.md
# Dual-Socket Card Control Register

This block is a one-byte configuration register in a card controller with two sockets. Each socket appears as its own configuration function. Each function keeps its own copy of the byte. Both copies together drive the routing outputs that the sockets share. Software selects a function, addresses the register at configuration offset 0x91, and reads or writes the byte.

Bit layout: bit 7 is the ring-indicate enable, bits 6..3 are spare storage, bit 2 is the audio-to-pin select, bit 1 is the speaker enable, and bit 0 is the socket interrupt flag.

- The ring-indicate enable exists once and belongs to function 0.
- The spare bits and the two routing enables are held separately in each function.
- The interrupt flag is set by hardware for each socket and is cleared by writing 1 to it.

The two speaker inputs are XOR-combined onto one speaker output, which comes with its own drive enable. A priority selector picks which socket's audio reaches the multifunction pin.

Top module: `card_ctl_reg`

## Requirements
- R1: After synchronous reset, both functions read 0x00 at offset 0x91, and ring_out_en, spk_oe, spk_out, aud_pin_en and aud_pin_data are all 0.
- R2: A write through function 0 (cfg_fn=0) at offset 0x91 loads bit 7 into ring_out_en on the next clock. A read through function 0 returns that value in bit 7.
- R3: A read through function 1 returns bit 7 as 0. A write through function 1 leaves ring_out_en unchanged, whatever its bit 7 holds.
- R4: Bits 6..3 hold the last value written through the same function. The two functions keep separate copies of these bits.
- R5: A write at any offset other than 0x91 changes no state. A read at any other offset returns 0x00.
- R6: spk_oe is 1 when bit 1 is set in at least one function. While spk_oe is 1, spk_out equals spk_in[0] XOR spk_in[1]. While spk_oe is 0, spk_out is 0.
- R7: bit 2 is the audio select.
  - aud_pin_en is 1 when bit 2 is set in at least one function.
  - aud_pin_src is the lowest function index whose bit 2 is set, so function 0 wins when both are set.
  - aud_pin_data is audio_in[aud_pin_src] while aud_pin_en is 1, and 0 otherwise.
- R8: A high level on sock_irq[n] during a clock edge sets bit 0 of function n. The bit stays set after sock_irq[n] returns low.
- R9: A write with bit 0 = 1 through function n clears that function's interrupt flag. A write with bit 0 = 0 leaves it unchanged.
- R10: When sock_irq[n] is high in the same cycle as a write-1-clear to function n, the flag ends set.
- R11: A synchronous reset applied while the register holds nonzero state returns every bit and output to the R1 values on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_fn | input | 1 | Function select for the access |
| cfg_addr | input | 8 | Configuration byte offset |
| cfg_wr | input | 1 | Write strobe |
| cfg_wdata | input | 8 | Write data |
| cfg_rdata | output | 8 | Read data for the addressed function and offset |
| sock_irq | input | 2 | Functional interrupt event per socket |
| spk_in | input | 2 | Speaker signal per socket |
| audio_in | input | 2 | Audio signal per socket |
| ring_out_en | output | 1 | Ring-indicate output enable |
| spk_out | output | 1 | Combined speaker data |
| spk_oe | output | 1 | Speaker output drive enable |
| aud_pin_en | output | 1 | Audio is routed to the multifunction pin |
| aud_pin_src | output | 1 | Socket whose audio is routed |
| aud_pin_data | output | 1 | Routed audio level |

## Verification
A socket interrupt event and a software write-1-clear of the same flag can arrive on the same clock edge. The bench produces this by raising sock_irq[0] in the very cycle that a write of bit 0 = 1 through function 0 is presented. It then reads the flag back through the configuration port and expects it still set. A later write-1-clear with no event present must then read back 0, which shows that the clear path works by itself.

// File: rtl/card_ctl_pkg.sv
package card_ctl_pkg;

    localparam int          CTL_W      = 8;
    localparam logic [7:0]  CTL_OFFSET = 8'h91;

    // Byte layout, most significant field first
    typedef struct packed {
        logic       ring_en;   // bit 7, shared
        logic [3:0] spare;     // bits 6..3
        logic       aud_sel;   // bit 2
        logic       spk_en;    // bit 1
        logic       irq_flag;  // bit 0
    } ctl_byte_t;

    localparam ctl_byte_t CTL_RESET = '0;

    function automatic ctl_byte_t as_ctl(input logic [CTL_W-1:0] raw);
        return ctl_byte_t'(raw);
    endfunction

endpackage

// File: rtl/card_fn_slice.sv
module card_fn_slice
    import card_ctl_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      wr_hit,
    input  logic [6:0] wr_low,
    input  logic      irq_evt,
    output ctl_byte_t q
);
    logic [3:0] spare_r;
    logic       aud_r;
    logic       spk_r;
    logic       flag_r;
    logic       clr_req;

    assign clr_req = wr_hit & wr_low[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            spare_r <= CTL_RESET.spare;
            aud_r   <= CTL_RESET.aud_sel;
            spk_r   <= CTL_RESET.spk_en;
            flag_r  <= CTL_RESET.irq_flag;
        end else begin
            if (wr_hit) begin
                spare_r <= wr_low[6:3];
                aud_r   <= wr_low[2];
                spk_r   <= wr_low[1];
            end
            // set has priority over write-one-clear
            if (irq_evt)
                flag_r <= 1'b1;
            else if (clr_req)
                flag_r <= 1'b0;
        end
    end

    always_comb begin
        q          = CTL_RESET;
        q.spare    = spare_r;
        q.aud_sel  = aud_r;
        q.spk_en   = spk_r;
        q.irq_flag = flag_r;
    end

endmodule

// File: rtl/card_spk_combine.sv
module card_spk_combine #(
    parameter int N = 2
) (
    input  logic [N-1:0] spk_in,
    input  logic [N-1:0] enable,
    output logic         spk_out,
    output logic         spk_oe
);
    assign spk_oe  = |enable;
    assign spk_out = spk_oe & (^spk_in);
endmodule

// File: rtl/card_aud_select.sv
module card_aud_select #(
    parameter int N  = 2,
    localparam int SW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  sel,
    input  logic [N-1:0]  audio_in,
    output logic          route_en,
    output logic [SW-1:0] route_src,
    output logic          route_data
);
    always_comb begin
        route_en  = 1'b0;
        route_src = '0;
        // scan downward so the lowest index is the final winner
        for (int i = N - 1; i >= 0; i--) begin
            if (sel[i]) begin
                route_en  = 1'b1;
                route_src = SW'(i);
            end
        end
    end

    assign route_data = route_en & audio_in[route_src];
endmodule

// File: rtl/card_ctl_reg.sv
module card_ctl_reg
    import card_ctl_pkg::*;
#(
    parameter int         NUM_FN     = 2,
    parameter logic [7:0] CFG_OFFSET = CTL_OFFSET,
    localparam int        FN_W       = (NUM_FN > 1) ? $clog2(NUM_FN) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [FN_W-1:0]   cfg_fn,
    input  logic [7:0]        cfg_addr,
    input  logic              cfg_wr,
    input  logic [CTL_W-1:0]  cfg_wdata,
    output logic [CTL_W-1:0]  cfg_rdata,
    input  logic [NUM_FN-1:0] sock_irq,
    input  logic [NUM_FN-1:0] spk_in,
    input  logic [NUM_FN-1:0] audio_in,
    output logic              ring_out_en,
    output logic              spk_out,
    output logic              spk_oe,
    output logic              aud_pin_en,
    output logic [FN_W-1:0]   aud_pin_src,
    output logic              aud_pin_data
);
    ctl_byte_t           fn_q [NUM_FN];
    logic [NUM_FN-1:0]   wr_hit;
    logic [NUM_FN-1:0]   flag_vec;
    logic [NUM_FN-1:0]   spk_vec;
    logic [NUM_FN-1:0]   aud_sel_vec;
    logic                addr_hit;
    logic                ring_r;
    ctl_byte_t           wbyte;
    ctl_byte_t           rbyte;

    assign addr_hit = (cfg_addr == CFG_OFFSET);
    assign wbyte    = as_ctl(cfg_wdata);

    for (genvar g = 0; g < NUM_FN; g++) begin : g_fn
        assign wr_hit[g] = cfg_wr & addr_hit & (cfg_fn == FN_W'(g));

        card_fn_slice u_slice (
            .clk     (clk),
            .rst     (rst),
            .wr_hit  (wr_hit[g]),
            .wr_low  (cfg_wdata[6:0]),
            .irq_evt (sock_irq[g]),
            .q       (fn_q[g])
        );

        assign flag_vec[g]    = fn_q[g].irq_flag;
        assign spk_vec[g]     = fn_q[g].spk_en;
        assign aud_sel_vec[g] = fn_q[g].aud_sel;
    end

    // Shared ring enable, owned by function 0 only
    always_ff @(posedge clk) begin
        if (rst)
            ring_r <= CTL_RESET.ring_en;
        else if (wr_hit[0])
            ring_r <= wbyte.ring_en;
    end

    always_comb begin
        rbyte = CTL_RESET;
        for (int i = 0; i < NUM_FN; i++) begin
            if (addr_hit && cfg_fn == FN_W'(i))
                rbyte = fn_q[i];
        end
        if (addr_hit && cfg_fn == '0)
            rbyte.ring_en = ring_r;
    end

    assign cfg_rdata   = rbyte;
    assign ring_out_en = ring_r;

    card_spk_combine #(.N(NUM_FN)) u_spk (
        .spk_in  (spk_in),
        .enable  (spk_vec),
        .spk_out (spk_out),
        .spk_oe  (spk_oe)
    );

    card_aud_select #(.N(NUM_FN)) u_aud (
        .sel        (aud_sel_vec),
        .audio_in   (audio_in),
        .route_en   (aud_pin_en),
        .route_src  (aud_pin_src),
        .route_data (aud_pin_data)
    );

endmodule

// File: rtl/card_ctl_chk.sv
module card_ctl_chk
    import card_ctl_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic [0:0] cfg_fn,
    input logic [7:0] cfg_addr,
    input logic       cfg_wr,
    input logic [7:0] cfg_wdata,
    input logic [1:0] sock_irq,
    input logic [1:0] spk_in,
    input logic [1:0] audio_in,
    input logic       ring_out_en,
    input logic       spk_out,
    input logic       spk_oe,
    input logic       aud_pin_en,
    input logic [0:0] aud_pin_src,
    input logic       aud_pin_data,
    input logic [1:0] flag_vec,
    input logic [1:0] aud_sel_vec
);
    // R1
    reset_clear_chk: assert property (@(posedge clk)
        $past(rst) |-> (!ring_out_en && !spk_oe && flag_vec == 2'b00 && !aud_pin_en));

    // R3
    ring_lock_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_wr && cfg_fn == 1'b1) |=> $stable(ring_out_en));

    // R6
    spk_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !spk_oe |-> !spk_out);

    // R6
    spk_xor_chk: assert property (@(posedge clk) disable iff (rst)
        spk_oe |-> (spk_out == (spk_in[0] ^ spk_in[1])));

    // R7
    aud_prio_chk: assert property (@(posedge clk) disable iff (rst)
        aud_sel_vec[0] |-> (aud_pin_en && aud_pin_src == 1'b0 && aud_pin_data == audio_in[0]));

    // R7
    aud_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !aud_pin_en |-> !aud_pin_data);

    // R8
    irq_set_chk: assert property (@(posedge clk) disable iff (rst)
        sock_irq[1] |=> flag_vec[1]);

    // R9
    irq_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_wr && cfg_addr == CTL_OFFSET && cfg_fn == 1'b0 && cfg_wdata[0] && !sock_irq[0])
        |=> !flag_vec[0]);

    // R10
    irq_race_chk: assert property (@(posedge clk) disable iff (rst)
        (sock_irq[0] && cfg_wr && cfg_addr == CTL_OFFSET && cfg_fn == 1'b0 && cfg_wdata[0])
        |=> flag_vec[0]);
endmodule

bind card_ctl_reg card_ctl_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .cfg_fn       (cfg_fn),
    .cfg_addr     (cfg_addr),
    .cfg_wr       (cfg_wr),
    .cfg_wdata    (cfg_wdata),
    .sock_irq     (sock_irq),
    .spk_in       (spk_in),
    .audio_in     (audio_in),
    .ring_out_en  (ring_out_en),
    .spk_out      (spk_out),
    .spk_oe       (spk_oe),
    .aud_pin_en   (aud_pin_en),
    .aud_pin_src  (aud_pin_src),
    .aud_pin_data (aud_pin_data),
    .flag_vec     (flag_vec),
    .aud_sel_vec  (aud_sel_vec)
);

// File: tb/sim_card_ctl_reg.sv
`timescale 1ns/1ps
module sim_card_ctl_reg;
    logic       clk = 1'b0;
    logic       rst;
    logic [0:0] cfg_fn;
    logic [7:0] cfg_addr;
    logic       cfg_wr;
    logic [7:0] cfg_wdata;
    logic [7:0] cfg_rdata;
    logic [1:0] sock_irq;
    logic [1:0] spk_in;
    logic [1:0] audio_in;
    logic       ring_out_en;
    logic       spk_out;
    logic       spk_oe;
    logic       aud_pin_en;
    logic [0:0] aud_pin_src;
    logic       aud_pin_data;

    int n_chk = 0;
    int n_bad = 0;

    localparam logic [7:0] OFS = 8'h91;

    always #4 clk = ~clk;   // 125 MHz

    card_ctl_reg u0 (
        .clk(clk), .rst(rst), .cfg_fn(cfg_fn), .cfg_addr(cfg_addr),
        .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .sock_irq(sock_irq), .spk_in(spk_in), .audio_in(audio_in),
        .ring_out_en(ring_out_en), .spk_out(spk_out), .spk_oe(spk_oe),
        .aud_pin_en(aud_pin_en), .aud_pin_src(aud_pin_src),
        .aud_pin_data(aud_pin_data)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic fn, input logic [7:0] addr, input logic [7:0] d);
        @(negedge clk);
        cfg_fn = fn; cfg_addr = addr; cfg_wdata = d; cfg_wr = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic fn, input logic [7:0] addr,
                          input logic [7:0] exp);
        cfg_fn = fn; cfg_addr = addr;
        #1;
        check(tag, int'(cfg_rdata), int'(exp));
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_reset();
        rd_chk("R1 fn0 read", 1'b0, OFS, 8'h00);
        rd_chk("R1 fn1 read", 1'b1, OFS, 8'h00);
        check("R1 ring", int'(ring_out_en), 0);
        check("R1 spk_oe", int'(spk_oe), 0);
        check("R1 aud_en", int'(aud_pin_en), 0);
    endtask

    task automatic t_ring();
        wr(1'b0, OFS, 8'h80);
        check("R2 ring set", int'(ring_out_en), 1);
        rd_chk("R2 fn0 readback", 1'b0, OFS, 8'h80);
        wr(1'b1, OFS, 8'h00);
        check("R3 fn1 write keeps ring", int'(ring_out_en), 1);
        wr(1'b1, OFS, 8'h80);
        rd_chk("R3 fn1 reads bit7 0", 1'b1, OFS, 8'h00);
        wr(1'b0, OFS, 8'h00);
        check("R2 ring clear", int'(ring_out_en), 0);
        wr(1'b1, OFS, 8'h80);
        check("R3 fn1 cannot set ring", int'(ring_out_en), 0);
    endtask

    task automatic t_spare();
        wr(1'b0, OFS, 8'h50);
        wr(1'b1, OFS, 8'h28);
        rd_chk("R4 fn0 spare", 1'b0, OFS, 8'h50);
        rd_chk("R4 fn1 spare", 1'b1, OFS, 8'h28);
        wr(1'b1, OFS, 8'h78);
        rd_chk("R4 fn0 untouched", 1'b0, OFS, 8'h50);
        wr(1'b0, OFS, 8'h00);
        wr(1'b1, OFS, 8'h00);
    endtask

    task automatic t_offset();
        wr(1'b0, 8'h90, 8'hFE);
        wr(1'b1, 8'h92, 8'hFE);
        rd_chk("R5 fn0 unchanged", 1'b0, OFS, 8'h00);
        rd_chk("R5 fn1 unchanged", 1'b1, OFS, 8'h00);
        check("R5 ring unchanged", int'(ring_out_en), 0);
        wr(1'b0, OFS, 8'h48);
        rd_chk("R5 other offset reads 0", 1'b0, 8'h90, 8'h00);
        wr(1'b0, OFS, 8'h00);
    endtask

    task automatic t_spk();
        spk_in = 2'b11; #1;
        check("R6 idle oe", int'(spk_oe), 0);
        check("R6 idle out", int'(spk_out), 0);
        wr(1'b1, OFS, 8'h02);
        check("R6 fn1 oe", int'(spk_oe), 1);
        for (int v = 0; v < 4; v++) begin
            spk_in = 2'(v); #1;
            check("R6 xor", int'(spk_out), int'(v == 1 || v == 2));
        end
        wr(1'b1, OFS, 8'h00);
        wr(1'b0, OFS, 8'h02);
        spk_in = 2'b01; #1;
        check("R6 fn0 oe", int'(spk_oe), 1);
        check("R6 fn0 out", int'(spk_out), 1);
        wr(1'b0, OFS, 8'h00);
        spk_in = 2'b01; #1;
        check("R6 off again", int'(spk_out), 0);
    endtask

    task automatic t_aud();
        audio_in = 2'b11; #1;
        check("R7 none en", int'(aud_pin_en), 0);
        check("R7 none data", int'(aud_pin_data), 0);
        wr(1'b1, OFS, 8'h04);
        audio_in = 2'b10; #1;
        check("R7 fn1 en", int'(aud_pin_en), 1);
        check("R7 fn1 src", int'(aud_pin_src), 1);
        check("R7 fn1 data hi", int'(aud_pin_data), 1);
        audio_in = 2'b01; #1;
        check("R7 fn1 data lo", int'(aud_pin_data), 0);
        wr(1'b0, OFS, 8'h04);
        audio_in = 2'b01; #1;
        check("R7 both src", int'(aud_pin_src), 0);
        check("R7 both data", int'(aud_pin_data), 1);
        wr(1'b1, OFS, 8'h00);
        audio_in = 2'b10; #1;
        check("R7 fn0 src", int'(aud_pin_src), 0);
        check("R7 fn0 data", int'(aud_pin_data), 0);
        wr(1'b0, OFS, 8'h00);
    endtask

    task automatic t_irq();
        @(negedge clk); sock_irq = 2'b10;
        @(negedge clk); sock_irq = 2'b00;
        repeat (3) @(negedge clk);
        rd_chk("R8 fn1 flag sticky", 1'b1, OFS, 8'h01);
        rd_chk("R8 fn0 flag clear", 1'b0, OFS, 8'h00);
        wr(1'b1, OFS, 8'h00);
        rd_chk("R9 write 0 keeps", 1'b1, OFS, 8'h01);
        wr(1'b1, OFS, 8'h01);
        rd_chk("R9 write 1 clears", 1'b1, OFS, 8'h00);
    endtask

    task automatic t_race();
        @(negedge clk);
        cfg_fn = 1'b0; cfg_addr = OFS; cfg_wdata = 8'h01; cfg_wr = 1'b1;
        sock_irq = 2'b01;
        @(negedge clk);
        cfg_wr = 1'b0; sock_irq = 2'b00;
        rd_chk("R10 set wins", 1'b0, OFS, 8'h01);
        wr(1'b0, OFS, 8'h01);
        rd_chk("R10 later clear", 1'b0, OFS, 8'h00);
    endtask

    task automatic t_midreset();
        wr(1'b0, OFS, 8'hF6);
        wr(1'b1, OFS, 8'h7A);
        @(negedge clk); sock_irq = 2'b11;
        @(negedge clk); sock_irq = 2'b00;
        check("R11 preload ring", int'(ring_out_en), 1);
        do_reset();
        rd_chk("R11 fn0 cleared", 1'b0, OFS, 8'h00);
        rd_chk("R11 fn1 cleared", 1'b1, OFS, 8'h00);
        check("R11 ring", int'(ring_out_en), 0);
        check("R11 spk_oe", int'(spk_oe), 0);
        check("R11 aud_en", int'(aud_pin_en), 0);
    endtask

    initial begin
        rst = 1'b1; cfg_fn = 1'b0; cfg_addr = 8'h00; cfg_wr = 1'b0;
        cfg_wdata = 8'h00; sock_irq = 2'b00; spk_in = 2'b00; audio_in = 2'b00;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_ring();
        t_spare();
        t_offset();
        t_spk();
        t_aud();
        t_irq();
        t_race();
        t_midreset();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule